// File: doc/BRIEF.md
# Nonoverlapping Pump Phase Sequencer

This block drives the switches of a charge pump with two flying capacitors. A fast system clock is divided down to a two-phase pump clock. Each half period begins with a short dead window in which neither phase is asserted. The selected boost ratio then decides which switches close in each phase. In doubling mode the two capacitors take turns: one charges from the battery while the other delivers to the output. In the one-and-a-half mode both capacitors charge in series in the first phase and are then stacked, in parallel, on top of the battery in the second. In pass-through mode a single switch ties the battery straight to the output and the flying capacitors stay idle.

The ratio input is sampled only at half-period boundaries, so a change always lands after a dead window. Dropping the enable opens every switch at the next clock edge. Clock frequency, pump frequency and dead time are parameters. The divider and dead-time counts are derived from them.

Top module: `cp_phase_seq`

## Requirements
- R1: While enabled, every half period lasts HALF = CLK_HZ/(2*PUMP_HZ) system cycles. `phi1_o` is asserted in the even halves, starting with the first half after enable, and `phi2_o` in the odd halves. Each phase is high for the last HALF-DEAD cycles of its half. The two phases are never high together, and they run in every ratio.
- R2: DEAD = ceil(DEAD_NS*CLK_HZ/1e9) cycles start every half period. During those cycles both phases are low and every flying-capacitor switch (`sw_o[9:1]`) is open.
- R3: Switch positions in `sw_o` are: bit 0 battery-to-output pass; bits 1..4 capacitor A top-to-battery, bottom-to-ground, top-to-output, bottom-to-battery; bits 5..8 the same four for capacitor B; bit 9 the series link from the bottom of A to the top of B.
- R4: Ratio code 2'b10 (double) gives this pattern in active cycles. In phase 1, bits 1,2,7,8 are closed. In phase 2, bits 3,4,5,6 are closed. No other bit is closed.
- R5: Ratio code 2'b01 (one and a half) gives this pattern in active cycles. In phase 1, bits 1,9,6 are closed. In phase 2, bits 3,4,7,8 are closed. No other bit is closed.
- R6: Ratio codes 2'b00 and 2'b11 (pass-through) close only bit 0. It stays closed across half periods. In the first half after entering pass-through, it stays open during that half's dead window.
- R7: The ratio input is sampled only on the clock edge that starts a half period. Changes at any other time have no effect until the next boundary.
- R8: With `en` low, all outputs are zero after the next clock edge. After `en` rises, the first edge starts a half period, and outputs for it appear one edge later.
- R9: After synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| en | input | 1 | pump enable; low opens every switch |
| mode | input | 2 | boost ratio: 00/11 pass, 01 one and a half, 10 double |
| phi1_o | output | 1 | first pump phase, dead-time gated |
| phi2_o | output | 1 | second pump phase, dead-time gated |
| sw_o | output | 10 | switch enables, bit map as in R3 |

## Verification
A wrong divider count or phase bit shows at the ports within one half period. The phase pulses lengthen, shorten or swap, and the switch pattern shifts with them. A latched ratio that is wrong, or taken at the wrong edge, shows as a wrong switch pattern in the next active cycle after a boundary. A leak through the dead window shows as a closed flying switch while both phases are low. The bench predicts each output cycle from the edge count since enable and the ratio seen at each boundary edge. It therefore catches any of these faults in the cycle it first appears.

// File: rtl/cpseq_pkg.sv
package cpseq_pkg;

    typedef enum logic [1:0] {
        PAT_OFF  = 2'd0,
        PAT_1X   = 2'd1,
        PAT_1P5X = 2'd2,
        PAT_2X   = 2'd3
    } pat_e;

    // per-capacitor switch group
    typedef struct packed {
        logic bot_bat;
        logic top_out;
        logic bot_gnd;
        logic top_bat;
    } cap_sw_t;

    // full switch word: bit 0 pass, 1..4 cap A, 5..8 cap B, 9 series link
    typedef struct packed {
        logic    ser_link;
        cap_sw_t cap_b;
        cap_sw_t cap_a;
        logic    pass;
    } sw_t;

    function automatic pat_e decode_ratio(input logic [1:0] code);
        case (code)
            2'b01:   return PAT_1P5X;
            2'b10:   return PAT_2X;
            default: return PAT_1X;
        endcase
    endfunction

    function automatic int half_cycles(input longint clk_hz, input longint pump_hz);
        return int'(clk_hz / (2 * pump_hz));
    endfunction

    function automatic int dead_cycles(input longint clk_hz, input longint dead_ns);
        return int'((dead_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    function automatic cap_sw_t cap_charge();
        cap_sw_t c;
        c = '0;
        c.top_bat = 1'b1;
        c.bot_gnd = 1'b1;
        return c;
    endfunction

    function automatic cap_sw_t cap_deliver();
        cap_sw_t c;
        c = '0;
        c.bot_bat = 1'b1;
        c.top_out = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/cpseq_timer.sv
module cpseq_timer #(
    parameter int HALF = 16,
    parameter int DEAD = 1,
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic start,
    output logic boundary,
    output logic phase,
    output logic active
);
    localparam logic [CW-1:0] LAST     = CW'(HALF - 1);
    localparam logic [CW-1:0] DEAD_END = CW'(DEAD);

    logic [CW-1:0] cnt_q;
    logic          ph_q;

    assign boundary = start || (cnt_q == LAST);
    assign phase    = ph_q;
    assign active   = (cnt_q >= DEAD_END);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (boundary) begin
            cnt_q <= '0;
            ph_q  <= start ? 1'b0 : ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpseq_ratio_latch.sv
module cpseq_ratio_latch
    import cpseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       boundary,
    input  logic [1:0] mode,
    output pat_e       pat,
    output pat_e       prev_pat
);
    pat_e pat_q, prev_q;

    assign pat      = pat_q;
    assign prev_pat = prev_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pat_q  <= PAT_OFF;
            prev_q <= PAT_OFF;
        end else if (boundary) begin
            prev_q <= pat_q;
            pat_q  <= decode_ratio(mode);
        end
    end
endmodule

// File: rtl/cpseq_switch_decode.sv
module cpseq_switch_decode
    import cpseq_pkg::*;
(
    input  pat_e pat,
    input  pat_e prev_pat,
    input  logic phase,
    input  logic active,
    output sw_t  sw,
    output logic phi1,
    output logic phi2
);
    logic    run;
    cap_sw_t dbl [2];

    assign run  = (pat != PAT_OFF);
    assign phi1 = run && active && !phase;
    assign phi2 = run && active && phase;

    // doubling: capacitor k charges on the phase where phase == k
    for (genvar k = 0; k < 2; k++) begin : g_dbl
        assign dbl[k] = (phase == k[0]) ? cap_charge() : cap_deliver();
    end

    always_comb begin
        sw = '0;
        unique case (pat)
            PAT_1X: sw.pass = active || (prev_pat == PAT_1X);
            PAT_1P5X: begin
                if (active) begin
                    if (!phase) begin
                        sw.cap_a.top_bat = 1'b1;
                        sw.ser_link      = 1'b1;
                        sw.cap_b.bot_gnd = 1'b1;
                    end else begin
                        sw.cap_a = cap_deliver();
                        sw.cap_b = cap_deliver();
                    end
                end
            end
            PAT_2X: begin
                if (active) begin
                    sw.cap_a = dbl[0];
                    sw.cap_b = dbl[1];
                end
            end
            default: sw = '0;
        endcase
    end
endmodule

// File: rtl/cp_phase_seq.sv
module cp_phase_seq
    import cpseq_pkg::*;
#(
    parameter int CLK_HZ  = 25_600_000,
    parameter int PUMP_HZ = 800_000,
    parameter int DEAD_NS = 35
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] mode,
    output logic       phi1_o,
    output logic       phi2_o,
    output logic [9:0] sw_o
);
    localparam int HALF = half_cycles(CLK_HZ, PUMP_HZ);
    localparam int DEAD = dead_cycles(CLK_HZ, DEAD_NS);

    logic boundary, phase, active;
    pat_e pat, prev_pat;
    sw_t  sw_d, sw_q;
    logic phi1_d, phi2_d, phi1_q, phi2_q;

    cpseq_timer #(.HALF(HALF), .DEAD(DEAD)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .start    (pat == PAT_OFF),
        .boundary (boundary),
        .phase    (phase),
        .active   (active)
    );

    cpseq_ratio_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .boundary (boundary),
        .mode     (mode),
        .pat      (pat),
        .prev_pat (prev_pat)
    );

    cpseq_switch_decode u_dec (
        .pat      (pat),
        .prev_pat (prev_pat),
        .phase    (phase),
        .active   (active),
        .sw       (sw_d),
        .phi1     (phi1_d),
        .phi2     (phi2_d)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sw_q   <= '0;
            phi1_q <= 1'b0;
            phi2_q <= 1'b0;
        end else begin
            sw_q   <= sw_d;
            phi1_q <= phi1_d;
            phi2_q <= phi2_d;
        end
    end

    assign sw_o   = sw_q;
    assign phi1_o = phi1_q;
    assign phi2_o = phi2_q;
endmodule

// File: rtl/cpseq_chk.sv
module cpseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       phi1,
    input logic       phi2,
    input logic [9:0] sw
);
    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(phi1 && phi2)); // R1

    AST_GAP_BEFORE_PHI1: assert property (@(posedge clk) disable iff (rst)
        $rose(phi1) |-> !$past(phi2)); // R2

    AST_GAP_BEFORE_PHI2: assert property (@(posedge clk) disable iff (rst)
        $rose(phi2) |-> !$past(phi1)); // R2

    AST_FLY_ONLY_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
        (sw[9:1] != 9'd0) |-> (phi1 || phi2)); // R2

    AST_PASS_ALONE: assert property (@(posedge clk) disable iff (rst)
        sw[0] |-> (sw[9:1] == 9'd0)); // R6

    AST_NO_CAP_A_SHORT: assert property (@(posedge clk) disable iff (rst)
        !(sw[1] && sw[3]) && !(sw[2] && sw[4])); // R3

    AST_NO_CAP_B_SHORT: assert property (@(posedge clk) disable iff (rst)
        !(sw[5] && sw[7]) && !(sw[6] && sw[8])); // R3

    AST_DISABLE_OPENS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sw == 10'd0 && !phi1 && !phi2)); // R8
endmodule

bind cp_phase_seq cpseq_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .phi1 (phi1_o),
    .phi2 (phi2_o),
    .sw   (sw_o)
);

// File: tb/cp_phase_seq_tb.sv
module cp_phase_seq_tb;
    localparam int  CLK_HZ  = 12_800_000;
    localparam int  PUMP_HZ = 800_000;
    localparam int  DEAD_NS = 160;
    localparam int  HALF    = CLK_HZ / (2 * PUMP_HZ);
    localparam int  DEAD    = int'((longint'(DEAD_NS) * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       phi1_o, phi2_o;
    logic [9:0] sw_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_edge = 0;
    int hist [0:4095];
    string churn_tag = "";
    bit done = 1'b0;

    always #4 clk = ~clk;

    cp_phase_seq #(.CLK_HZ(CLK_HZ), .PUMP_HZ(PUMP_HZ), .DEAD_NS(DEAD_NS)) u_dut (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .phi1_o(phi1_o), .phi2_o(phi2_o), .sw_o(sw_o)
    );

    // bench ratio class: 1 pass, 2 one and a half, 3 double, 0 off
    function automatic int cls(input int code);
        if (code == 1) return 2;
        if (code == 2) return 3;
        return 1;
    endfunction

    // R3 bit map: 0 pass; A 1 top-bat, 2 bot-gnd, 3 top-out, 4 bot-bat; B 5..8; 9 series
    function automatic logic [9:0] exp_sw(input int md, input int pv, input int ph, input bit act);
        logic [9:0] v = '0;
        if (md == 1) v[0] = act || (pv == 1);
        else if (md == 2 && act) begin
            if (ph == 0) begin v[1] = 1; v[9] = 1; v[6] = 1; end
            else begin v[3] = 1; v[4] = 1; v[7] = 1; v[8] = 1; end
        end else if (md == 3 && act) begin
            if (ph == 0) begin v[1] = 1; v[2] = 1; v[7] = 1; v[8] = 1; end
            else begin v[5] = 1; v[6] = 1; v[3] = 1; v[4] = 1; end
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [11:0] act_v, input logic [11:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s edge=%0d actual phi2,phi1,sw=%b expected=%b", tag, n_edge, act_v, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (en && !rst) begin
            n_edge++;
            if (n_edge < 4096) hist[n_edge] = cls(int'(mode));
        end else n_edge = 0;
        #4;
        if (n_edge < 2) begin
            check(rst ? "R9" : "R8", {phi2_o, phi1_o, sw_o}, 12'd0);
        end else begin
            int j, h, w, ph, md, pv;
            bit act;
            string tag;
            j  = n_edge - 2;
            h  = j / HALF;
            w  = j % HALF;
            ph = h % 2;
            act = (w >= DEAD);
            md = hist[1 + h * HALF];
            pv = (h == 0) ? 0 : hist[1 + (h - 1) * HALF];
            if (churn_tag != "") tag = churn_tag;
            else if (!act) tag = "R2";
            else if (md == 1) tag = "R6";
            else if (md == 2) tag = "R5";
            else tag = "R4";
            check(tag, {phi2_o, phi1_o, sw_o}, {act && ph == 1, act && ph == 0, exp_sw(md, pv, ph, act)});
            check("R1", {10'd0, phi2_o, phi1_o}, {10'd0, act && ph == 1, act && ph == 0});
        end
    endtask

    initial begin
        #(8 * 200_000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R9: outputs idle under and after reset
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        step();
        // R4 R5 R6 R8: sweep every ratio pair with changes mid-half
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                mode = 2'(a);
                en   = 1'b1;
                for (int i = 0; i < 4 * HALF + 3; i++) step();
                mode = 2'(b);
                for (int i = 0; i < 5 * HALF + a * 4 + b; i++) step();
                en = 1'b0;
                step();
                step();
            end
        end
        // R7: ratio churns every cycle, only boundary samples count
        churn_tag = "R7";
        en = 1'b1;
        for (int i = 0; i < 12 * HALF; i++) begin
            mode = 2'((i * 7 + i / 3) % 4);
            step();
        end
        en = 1'b0;
        churn_tag = "";
        step();
        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule